// File: doc/BRIEF.md
# Link Heartbeat and Recovery Sequencer

This block watches a serial link whose controller raises no interrupt on a state change. It reads a link-control register on a fixed heartbeat and compares the link-down flag with the state it last recorded. It raises a one-cycle event only when the two differ. On every transition to up it reads a status word and keeps the negotiated lane width and speed. On a transition to down it leaves those stored values alone.

While the link is down, each poll also reads the state-jump register. If that register shows the PHY forced into detect, polling stops and a recovery sequence runs over the register port:

1. Four byte writes reset the PHY lanes.
2. A settle wait follows.
3. Four error-status registers are cleared by read-modify-write.
4. The force-detect bit is released.
5. A retrain wait follows, and then three reads judge the outcome.

A failed outcome waits out a slower retry period and starts the sequence again from the PHY writes. A good outcome returns to heartbeat polling.

All durations count pulses of a tick input, so one parameter set covers both real time and short test runs. The register port is a single-request master with a req/ack handshake.

Top module: `link_watchdog_seq`

## Requirements
- R1: After reset the first poll starts at once. After that, the link-control register (address A_CTRL) is read once every HB_TICKS tick pulses. The time counts from the end of the previous poll's accesses.
- R2: The link is taken as up when bit LDN_BIT of the control word is 0. `evt_up_o` or `evt_down_o` pulses for one cycle only when the sampled state differs from the stored one, and the two never pulse together. The stored state after reset is down.
- R3: On a down-to-up transition the status register (A_STAT) is read. Width is taken from bits [WID_LSB+WID_W-1:WID_LSB] (bits [9:4] by default) and speed from bits [SPD_W-1:0] (bits [3:0]). Both are stored and driven on `link_width_o`/`link_speed_o`, and `evt_up_o` pulses with them.
- R4: On an up-to-down transition the stored width and speed stay unchanged, whatever the status register holds.
- R5: While the link is down, each poll reads A_JUMP. Recovery starts, and `recov_start_o` pulses, only if bit FD_BIT is set. No control-register read happens from that point until recovery succeeds.
- R6: Recovery begins with four writes in this order: A_PHY6=0xE0, A_PHY4=0x40, A_PHY4=0x60, A_PHY6=0x60.
- R7: After a wait of SETTLE_TICKS ticks, four registers are each read and then written back, in this order:
  - A_ERRCOR, written with (read AND bit ROLL_BIT);
  - A_EIERR, written with (read OR bit EI_BIT);
  - A_DESKEW, written with (read OR bit DB_BIT);
  - A_IBIST, written with (read AND bit OF_BIT).
- R8: Last, A_JUMP is read and written back with bit FD_BIT cleared. A wait of RETRAIN_TICKS ticks follows before any check.
- R9: The check reads A_JUMP, then A_IBIST, then A_STAT. Recovery fails if FD_BIT is set, or OF_BIT is set, or the width or speed differs from the stored values. A failure pulses `recov_retry_o`, waits RETRY_TICKS ticks and restarts at the first PHY write.
- R10: A passing check pulses `recov_ok_o` and returns to heartbeat polling, so a later link-up is reported.
- R11: Only one register access is outstanding. A request holds its address, direction and data stable until it is acknowledged.
- R12: A synchronous active-high reset clears all events, the request, the link state, width and speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base pulse; all waits count these |
| bus_req_o | output | 1 | Register access request, held until ack |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Register address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid |
| bus_rdata_i | input | DW | Read data |
| link_up_o | output | 1 | Stored link state |
| link_width_o | output | WID_W | Stored negotiated width |
| link_speed_o | output | SPD_W | Stored negotiated speed |
| evt_up_o | output | 1 | One-cycle link-up event |
| evt_down_o | output | 1 | One-cycle link-down event |
| recov_start_o | output | 1 | One-cycle pulse when recovery is entered |
| recov_retry_o | output | 1 | One-cycle pulse when a recovery check fails |
| recov_ok_o | output | 1 | One-cycle pulse when a recovery check passes |

## Verification
Two activities can meet in one clock cycle:

- **Tick and acknowledge.** A tick pulse can arrive in the same cycle as a bus acknowledge that ends the access before a wait. The bench runs the tick on a fixed period and gives the acknowledge a random latency of zero to two cycles. That makes the two coincide at different points of the heartbeat, settle, retrain and retry windows. Each window is judged by the cycle distance between the logged accesses on either side of it, which must not fall below the programmed tick count.
- **Link change and recovery.** The link can change while recovery is running, and the bench shows that no control read occurs until the success pulse. The bench also forces each of the three failure causes by making the register model hold the flag or a changed width. It then checks that the retry pulse appears and that the sequence restarts at the first PHY write.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [3:0] {
    ST_POLL,      // read link-control word
    ST_STAT,      // read status word on up transition
    ST_JUMP,      // read state-jump word while down
    ST_HB,        // heartbeat wait
    ST_PHY,       // PHY lane reset writes
    ST_SETTLE,    // settle wait
    ST_CLR_RD,    // error-clear read
    ST_CLR_WR,    // error-clear write back
    ST_RETRAIN,   // retrain wait
    ST_CHK_FD,    // check force-detect
    ST_CHK_OF,    // check overflow flag
    ST_CHK_ST,    // check width and speed
    ST_RETRY      // retry wait
  } lrs_state_e;

  localparam int PHY_STEPS = 4;
  localparam int CLR_STEPS = 5;

endpackage

// File: rtl/lrs_tick_timer.sv
module lrs_tick_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      armed  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (armed && tick_i) begin
        if (cnt == limit_i - CW'(1)) begin
          armed  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R1: a wait can only end on a tick
  p_done_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(tick_i));

endmodule

// File: rtl/lrs_bus_master.sv
module lrs_bus_master #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (req_o && ack_i) begin
        req_o   <= 1'b0;
        done_o  <= 1'b1;
        rdata_o <= rdata_i;
      end else if (go_i && !req_o) begin
        req_o   <= 1'b1;
        we_o    <= we_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
    end
  end

  // R11: request held stable until acknowledged
  p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  // R11: the sequencer never issues while an access is open
  p_single_go_r11: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !req_o);

endmodule

// File: rtl/link_watchdog_seq.sv
module link_watchdog_seq
  import lrs_pkg::*;
#(
  parameter int AW            = 8,
  parameter int DW            = 32,
  parameter int CW            = 16,
  parameter int HB_TICKS      = 1000,
  parameter int SETTLE_TICKS  = 100,
  parameter int RETRAIN_TICKS = 500,
  parameter int RETRY_TICKS   = 1000,
  parameter logic [AW-1:0] A_CTRL   = 'h00,
  parameter logic [AW-1:0] A_STAT   = 'h04,
  parameter logic [AW-1:0] A_JUMP   = 'h08,
  parameter logic [AW-1:0] A_PHY6   = 'h10,
  parameter logic [AW-1:0] A_PHY4   = 'h14,
  parameter logic [AW-1:0] A_ERRCOR = 'h20,
  parameter logic [AW-1:0] A_EIERR  = 'h24,
  parameter logic [AW-1:0] A_DESKEW = 'h28,
  parameter logic [AW-1:0] A_IBIST  = 'h2C,
  parameter int LDN_BIT  = 1,
  parameter int FD_BIT   = 3,
  parameter int ROLL_BIT = 8,
  parameter int EI_BIT   = 3,
  parameter int DB_BIT   = 4,
  parameter int OF_BIT   = 6,
  parameter int WID_LSB  = 4,
  parameter int WID_W    = 6,
  parameter int SPD_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic             bus_ack_i,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             link_up_o,
  output logic [WID_W-1:0] link_width_o,
  output logic [SPD_W-1:0] link_speed_o,
  output logic             evt_up_o,
  output logic             evt_down_o,
  output logic             recov_start_o,
  output logic             recov_retry_o,
  output logic             recov_ok_o
);

  localparam logic [DW-1:0] ONE       = DW'(1);
  localparam logic [DW-1:0] FD_MASK   = ONE << FD_BIT;
  localparam logic [DW-1:0] ROLL_MASK = ONE << ROLL_BIT;
  localparam logic [DW-1:0] EI_MASK   = ONE << EI_BIT;
  localparam logic [DW-1:0] DB_MASK   = ONE << DB_BIT;
  localparam logic [DW-1:0] OF_MASK   = ONE << OF_BIT;
  localparam int PIW = $clog2(PHY_STEPS);
  localparam int CIW = $clog2(CLR_STEPS);

  lrs_state_e       state;
  logic             pend;
  logic [PIW-1:0]   pi;
  logic [CIW-1:0]   ci;
  logic [DW-1:0]    rbuf;

  logic             cmd_go, cmd_we, bus_state, tmr_state, tmr_start, tmr_done;
  logic [AW-1:0]    cmd_addr;
  logic [DW-1:0]    cmd_wdata;
  logic [CW-1:0]    tmr_limit;
  logic             bus_done;
  logic [DW-1:0]    bus_rdata;
  logic             now_up, in_recov, stat_match;
  logic [7:0]       phy_byte;
  logic [AW-1:0]    clr_addr;
  logic [DW-1:0]    clr_data;

  // ---------------- command decode ----------------
  always_comb begin
    case (pi)
      PIW'(0): phy_byte = 8'hE0;
      PIW'(1): phy_byte = 8'h40;
      default: phy_byte = 8'h60;
    endcase
  end

  always_comb begin
    case (ci)
      CIW'(0): begin clr_addr = A_ERRCOR; clr_data = rbuf & ROLL_MASK; end
      CIW'(1): begin clr_addr = A_EIERR;  clr_data = rbuf | EI_MASK;   end
      CIW'(2): begin clr_addr = A_DESKEW; clr_data = rbuf | DB_MASK;   end
      CIW'(3): begin clr_addr = A_IBIST;  clr_data = rbuf & OF_MASK;   end
      default: begin clr_addr = A_JUMP;   clr_data = rbuf & ~FD_MASK;  end
    endcase
  end

  always_comb begin
    cmd_we    = 1'b0;
    cmd_addr  = A_CTRL;
    cmd_wdata = '0;
    bus_state = 1'b1;
    case (state)
      ST_POLL:             cmd_addr = A_CTRL;
      ST_STAT, ST_CHK_ST:  cmd_addr = A_STAT;
      ST_JUMP, ST_CHK_FD:  cmd_addr = A_JUMP;
      ST_CHK_OF:           cmd_addr = A_IBIST;
      ST_PHY: begin
        cmd_we    = 1'b1;
        cmd_addr  = (pi == PIW'(0) || pi == PIW'(PHY_STEPS-1)) ? A_PHY6 : A_PHY4;
        cmd_wdata = {{(DW-8){1'b0}}, phy_byte};
      end
      ST_CLR_RD:           cmd_addr = clr_addr;
      ST_CLR_WR: begin
        cmd_we    = 1'b1;
        cmd_addr  = clr_addr;
        cmd_wdata = clr_data;
      end
      default:             bus_state = 1'b0;
    endcase
  end

  always_comb begin
    tmr_state = 1'b1;
    case (state)
      ST_HB:      tmr_limit = CW'(HB_TICKS);
      ST_SETTLE:  tmr_limit = CW'(SETTLE_TICKS);
      ST_RETRAIN: tmr_limit = CW'(RETRAIN_TICKS);
      ST_RETRY:   tmr_limit = CW'(RETRY_TICKS);
      default: begin
        tmr_state = 1'b0;
        tmr_limit = CW'(1);
      end
    endcase
  end

  assign cmd_go     = bus_state && !pend;
  assign tmr_start  = tmr_state && !pend;
  assign now_up     = ~bus_rdata[LDN_BIT];
  assign stat_match = (bus_rdata[WID_LSB +: WID_W] == link_width_o) &&
                      (bus_rdata[0 +: SPD_W] == link_speed_o);
  assign in_recov   = !(state inside {ST_POLL, ST_STAT, ST_JUMP, ST_HB});

  // ---------------- submodules ----------------
  lrs_bus_master #(.AW(AW), .DW(DW)) i_bus (
    .clk(clk), .rst(rst),
    .go_i(cmd_go), .we_i(cmd_we), .addr_i(cmd_addr), .wdata_i(cmd_wdata),
    .done_o(bus_done), .rdata_o(bus_rdata),
    .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o),
    .ack_i(bus_ack_i), .rdata_i(bus_rdata_i)
  );

  lrs_tick_timer #(.CW(CW)) i_tmr (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .start_i(tmr_start), .limit_i(tmr_limit), .done_o(tmr_done)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_POLL;
      pend          <= 1'b0;
      pi            <= '0;
      ci            <= '0;
      rbuf          <= '0;
      link_up_o     <= 1'b0;
      link_width_o  <= '0;
      link_speed_o  <= '0;
      evt_up_o      <= 1'b0;
      evt_down_o    <= 1'b0;
      recov_start_o <= 1'b0;
      recov_retry_o <= 1'b0;
      recov_ok_o    <= 1'b0;
    end else begin
      evt_up_o      <= 1'b0;
      evt_down_o    <= 1'b0;
      recov_start_o <= 1'b0;
      recov_retry_o <= 1'b0;
      recov_ok_o    <= 1'b0;
      if (cmd_go || tmr_start) pend <= 1'b1;
      if (bus_done || tmr_done) pend <= 1'b0;
      case (state)
        ST_POLL: if (bus_done) begin
          if (now_up && !link_up_o) begin
            state <= ST_STAT;
          end else if (!now_up) begin
            if (link_up_o) begin
              link_up_o  <= 1'b0;
              evt_down_o <= 1'b1;
            end
            state <= ST_JUMP;
          end else begin
            state <= ST_HB;
          end
        end
        ST_STAT: if (bus_done) begin
          link_width_o <= bus_rdata[WID_LSB +: WID_W];
          link_speed_o <= bus_rdata[0 +: SPD_W];
          link_up_o    <= 1'b1;
          evt_up_o     <= 1'b1;
          state        <= ST_HB;
        end
        ST_JUMP: if (bus_done) begin
          if ((bus_rdata & FD_MASK) != '0) begin
            recov_start_o <= 1'b1;
            pi            <= '0;
            state         <= ST_PHY;
          end else begin
            state <= ST_HB;
          end
        end
        ST_HB: if (tmr_done) state <= ST_POLL;
        ST_PHY: if (bus_done) begin
          if (pi == PIW'(PHY_STEPS-1)) state <= ST_SETTLE;
          else                         pi    <= pi + PIW'(1);
        end
        ST_SETTLE: if (tmr_done) begin
          ci    <= '0;
          state <= ST_CLR_RD;
        end
        ST_CLR_RD: if (bus_done) begin
          rbuf  <= bus_rdata;
          state <= ST_CLR_WR;
        end
        ST_CLR_WR: if (bus_done) begin
          if (ci == CIW'(CLR_STEPS-1)) begin
            state <= ST_RETRAIN;
          end else begin
            ci    <= ci + CIW'(1);
            state <= ST_CLR_RD;
          end
        end
        ST_RETRAIN: if (tmr_done) state <= ST_CHK_FD;
        ST_CHK_FD: if (bus_done) begin
          if ((bus_rdata & FD_MASK) != '0) begin
            recov_retry_o <= 1'b1;
            state         <= ST_RETRY;
          end else begin
            state <= ST_CHK_OF;
          end
        end
        ST_CHK_OF: if (bus_done) begin
          if ((bus_rdata & OF_MASK) != '0) begin
            recov_retry_o <= 1'b1;
            state         <= ST_RETRY;
          end else begin
            state <= ST_CHK_ST;
          end
        end
        ST_CHK_ST: if (bus_done) begin
          if (stat_match) begin
            recov_ok_o <= 1'b1;
            state      <= ST_HB;
          end else begin
            recov_retry_o <= 1'b1;
            state         <= ST_RETRY;
          end
        end
        ST_RETRY: if (tmr_done) begin
          pi    <= '0;
          state <= ST_PHY;
        end
        default: state <= ST_POLL;
      endcase
    end
  end

  // R2: up and down events are exclusive
  p_evt_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(evt_up_o && evt_down_o));

  // R2: an up event only follows a stored down state
  p_up_after_down_r2: assert property (@(posedge clk) disable iff (rst)
    evt_up_o |-> !$past(link_up_o));

  // R4: width and speed are kept across a down event
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    evt_down_o |-> ($stable(link_width_o) && $stable(link_speed_o)));

  // R5: heartbeat polling is halted during recovery
  p_no_poll_r5: assert property (@(posedge clk) disable iff (rst)
    (in_recov && bus_req_o) |-> (bus_addr_o != A_CTRL));

  // R9: retry and success are never reported together
  p_outcome_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(recov_retry_o && recov_ok_o));

  // R12: no event right after reset release is driven from reset values
  p_quiet_after_reset_r12: assert property (@(posedge clk)
    $fell(rst) |-> (!evt_up_o && !evt_down_o && !bus_req_o && !link_up_o));

endmodule

// File: tb/test_link_watchdog_seq.sv
module test_link_watchdog_seq;

  localparam int AW = 8, DW = 32, CW = 8;
  localparam int TP = 4;                         // cycles per tick
  localparam int HB = 5, SET = 3, RTR = 4, RTY = 6;
  localparam logic [AW-1:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_JUMP = 8'h08,
    A_PHY6 = 8'h10, A_PHY4 = 8'h14, A_ERRCOR = 8'h20, A_EIERR = 8'h24,
    A_DESKEW = 8'h28, A_IBIST = 8'h2C;
  localparam logic [DW-1:0] LDN = 32'h2, FD = 32'h8, ROLL = 32'h100,
    EI = 32'h8, DB = 32'h10, OF = 32'h40;
  localparam int LOGN = 4096;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic req, we, ack = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata = '0;
  logic up, e_up, e_dn, r_st, r_rt, r_ok;
  logic [5:0] wid;
  logic [3:0] spd;

  always #4 clk = ~clk;   // 125 MHz

  link_watchdog_seq #(.AW(AW), .DW(DW), .CW(CW), .HB_TICKS(HB), .SETTLE_TICKS(SET),
    .RETRAIN_TICKS(RTR), .RETRY_TICKS(RTY)) i_link_watchdog_seq (
    .clk(clk), .rst(rst), .tick_i(tick),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata),
    .link_up_o(up), .link_width_o(wid), .link_speed_o(spd),
    .evt_up_o(e_up), .evt_down_o(e_dn), .recov_start_o(r_st),
    .recov_retry_o(r_rt), .recov_ok_o(r_ok));

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_up = 0, n_dn = 0, n_st = 0, n_rt = 0, n_ok = 0;
  int st_mark = 0, rt_mark = 0, c_rt = 0, ok_mark = 0;
  int viol = 0;
  bit finished = 0;

  // register model
  logic [DW-1:0] m_ctrl = LDN, m_stat = '0, m_jump = '0, m_err = '0,
                 m_ei = '0, m_desk = '0, m_ib = '0, m_p6 = '0, m_p4 = '0;
  bit fd_stuck = 0, of_stuck = 0;
  logic          lg_we   [LOGN];
  logic [AW-1:0] lg_addr [LOGN];
  logic [DW-1:0] lg_data [LOGN];
  int            lg_cyc  [LOGN];
  int            log_n = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mread(input logic [AW-1:0] a);
    case (a)
      A_CTRL:   return m_ctrl;
      A_STAT:   return m_stat;
      A_JUMP:   return m_jump;
      A_ERRCOR: return m_err;
      A_EIERR:  return m_ei;
      A_DESKEW: return m_desk;
      A_IBIST:  return m_ib;
      A_PHY6:   return m_p6;
      A_PHY4:   return m_p4;
      default:  return '0;
    endcase
  endfunction

  task automatic mwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    case (a)
      A_JUMP:   m_jump = fd_stuck ? (d | FD) : d;
      A_ERRCOR: m_err  = m_err & ~d;
      A_EIERR:  m_ei   = m_ei & ~d;
      A_DESKEW: m_desk = m_desk & ~d;
      A_IBIST:  m_ib   = of_stuck ? ((m_ib & ~d) | OF) : (m_ib & ~d);
      A_PHY6:   m_p6   = d;
      A_PHY4:   m_p4   = d;
      default:  ;
    endcase
  endtask

  // bus responder with random latency; also checks R11 handshake hold
  initial begin
    int lat = 0;
    bit armed = 0, p_req = 0, p_ack = 0;
    logic [AW-1:0] p_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      tick = (cyc % TP) == 0;
      if (p_req && !p_ack && (!req || addr != p_addr)) viol++;
      if (ack) ack = 1'b0;
      else if (req) begin
        if (!armed) begin lat = int'($urandom % 3); armed = 1; end
        if (lat == 0) begin
          if (we) mwrite(addr, wdata);
          else    rdata = mread(addr);
          if (log_n < LOGN) begin
            lg_we[log_n] = we; lg_addr[log_n] = addr;
            lg_data[log_n] = we ? wdata : rdata; lg_cyc[log_n] = cyc;
            log_n++;
          end
          ack = 1'b1; armed = 0;
        end else lat--;
      end
      p_req = req; p_ack = ack; p_addr = addr;
    end
  end

  // event monitor
  initial begin
    forever begin
      @(negedge clk);
      if (e_up) n_up++;
      if (e_dn) n_dn++;
      if (r_st) begin n_st++; st_mark = log_n; end
      if (r_rt) begin n_rt++; rt_mark = log_n; c_rt = cyc; end
      if (r_ok) begin n_ok++; ok_mark = log_n; end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [DW-1:0] exp_clr(input int k, input logic [DW-1:0] rd);
    case (k)
      0: return rd & ROLL;
      1: return rd | EI;
      2: return rd | DB;
      3: return rd & OF;
      default: return rd & ~FD;
    endcase
  endfunction

  function automatic logic [AW-1:0] clr_addr(input int k);
    case (k)
      0: return A_ERRCOR;
      1: return A_EIERR;
      2: return A_DESKEW;
      3: return A_IBIST;
      default: return A_JUMP;
    endcase
  endfunction

  task automatic wait_up(input int base);
    for (int k = 0; k < 600 && n_up == base; k++) @(negedge clk);
  endtask
  task automatic wait_dn(input int base);
    for (int k = 0; k < 600 && n_dn == base; k++) @(negedge clk);
  endtask
  task automatic wait_ok(input int base);
    for (int k = 0; k < 3000 && n_ok == base; k++) @(negedge clk);
  endtask
  task automatic wait_rt(input int base);
    for (int k = 0; k < 3000 && n_rt == base; k++) @(negedge clk);
  endtask

  task automatic bring_up(input int w, input int s, input string rq);
    int b;
    b = n_up;
    m_stat = DW'((w << 4) | s);
    m_ctrl = '0;
    wait_up(b);
    chk(n_up == b + 1, {rq, " up event"}, n_up - b, 1);
    chk(up == 1'b1 && int'(wid) == w && int'(spd) == s, {rq, " width/speed"},
        int'({wid, spd}), (w << 4) | s);
  endtask

  initial begin
    int seed, b, ix, last, prev, w, s;
    seed = int'($urandom(32'h5eed));
    // R12 reset state
    repeat (5) @(negedge clk);
    chk(!req && !e_up && !e_dn && !up && wid == 0 && spd == 0 && !r_st,
        "R12 reset outputs", int'({req, e_up, e_dn, up}), 0);
    rst = 1'b0;

    // R1 heartbeat period with link down and no force-detect
    repeat (150) @(negedge clk);
    last = -1; prev = -1;
    for (int i = log_n - 1; i >= 0 && prev < 0; i--)
      if (!lg_we[i] && lg_addr[i] == A_CTRL) begin
        if (last < 0) last = i; else prev = i;
      end
    chk(prev >= 0 && lg_cyc[last] - lg_cyc[prev] >= HB * TP - TP &&
        lg_cyc[last] - lg_cyc[prev] <= HB * TP + 24, "R1 poll interval",
        lg_cyc[last] - lg_cyc[prev], HB * TP);
    chk(n_up == 0 && n_dn == 0 && n_st == 0, "R2 no event on steady down", n_up + n_dn, 0);

    // random up/down cycles: R2 R3 R4
    for (int it = 0; it < 4; it++) begin
      w = 1 + int'($urandom % 63);
      s = 1 + int'($urandom % 15);
      bring_up(w, s, "R3");
      b = n_up;
      repeat (100) @(negedge clk);
      chk(n_up == b && n_dn == 0 + it, "R2 no repeat event", n_up - b, 0);
      m_stat = 32'h3FF;             // junk status, must not be captured on down
      b = n_dn;
      m_ctrl = LDN;
      wait_dn(b);
      chk(n_dn == b + 1 && !up, "R2 down event", n_dn - b, 1);
      chk(int'(wid) == w && int'(spd) == s, "R4 width/speed kept", int'({wid, spd}), (w << 4) | s);
      repeat (40) @(negedge clk);
      chk(n_st == 0, "R5 no recovery without force-detect", n_st, 0);
    end

    // directed recovery success: R5 R6 R7 R8 R10
    bring_up(12, 2, "R3");
    m_err = ROLL | 32'h1; m_ei = '0; m_desk = '0; m_ib = OF; m_jump = FD;
    b = n_ok;
    m_ctrl = LDN;
    wait_ok(b);
    chk(n_ok == b + 1 && n_rt == 0 && n_st == 1, "R10 recovery ok", n_ok - b, 1);
    ix = st_mark;
    chk(lg_we[ix] && lg_addr[ix] == A_PHY6 && lg_data[ix] == 32'hE0, "R6 phy write 0", int'(lg_data[ix]), 'hE0);
    chk(lg_we[ix+1] && lg_addr[ix+1] == A_PHY4 && lg_data[ix+1] == 32'h40, "R6 phy write 1", int'(lg_data[ix+1]), 'h40);
    chk(lg_we[ix+2] && lg_addr[ix+2] == A_PHY4 && lg_data[ix+2] == 32'h60, "R6 phy write 2", int'(lg_data[ix+2]), 'h60);
    chk(lg_we[ix+3] && lg_addr[ix+3] == A_PHY6 && lg_data[ix+3] == 32'h60, "R6 phy write 3", int'(lg_data[ix+3]), 'h60);
    chk(lg_cyc[ix+4] - lg_cyc[ix+3] >= (SET - 1) * TP, "R7 settle wait", lg_cyc[ix+4] - lg_cyc[ix+3], SET * TP);
    for (int k = 0; k < 5; k++) begin
      chk(!lg_we[ix+4+2*k] && lg_addr[ix+4+2*k] == clr_addr(k), "R7 clear read order",
          int'(lg_addr[ix+4+2*k]), int'(clr_addr(k)));
      chk(lg_we[ix+5+2*k] && lg_addr[ix+5+2*k] == clr_addr(k) &&
          lg_data[ix+5+2*k] == exp_clr(k, lg_data[ix+4+2*k]), k == 4 ? "R8 release write" : "R7 clear write",
          int'(lg_data[ix+5+2*k]), int'(exp_clr(k, lg_data[ix+4+2*k])));
    end
    chk(m_err == 32'h1, "R7 only rollover cleared", int'(m_err), 1);
    chk(lg_cyc[ix+14] - lg_cyc[ix+13] >= (RTR - 1) * TP && lg_addr[ix+14] == A_JUMP,
        "R8 retrain wait", lg_cyc[ix+14] - lg_cyc[ix+13], RTR * TP);
    chk(lg_addr[ix+15] == A_IBIST && lg_addr[ix+16] == A_STAT, "R9 check order",
        int'(lg_addr[ix+15]), int'(A_IBIST));
    b = 0;
    for (int i = ix; i < ok_mark; i++) if (lg_addr[i] == A_CTRL) b++;
    chk(b == 0, "R5 polling halted", b, 0);
    bring_up(12, 2, "R10 resume");

    // R9: width mismatch then restart
    m_stat = DW'((20 << 4) | 2); m_jump = FD;
    b = n_rt;
    m_ctrl = LDN;
    wait_rt(b);
    chk(n_rt == b + 1, "R9 retry on width change", n_rt - b, 1);
    m_stat = DW'((12 << 4) | 2);
    b = n_ok;
    wait_ok(b);
    chk(n_ok == b + 1, "R9 ok after retry", n_ok - b, 1);
    chk(lg_we[rt_mark] && lg_addr[rt_mark] == A_PHY6 && lg_data[rt_mark] == 32'hE0,
        "R9 restart at phy write", int'(lg_addr[rt_mark]), int'(A_PHY6));
    chk(lg_cyc[rt_mark] - c_rt >= (RTY - 1) * TP, "R9 retry wait", lg_cyc[rt_mark] - c_rt, RTY * TP);

    // R9: force-detect stuck
    fd_stuck = 1; m_jump = FD;
    b = n_rt;
    wait_rt(b);
    chk(n_rt == b + 1, "R9 retry on force-detect", n_rt - b, 1);
    fd_stuck = 0;
    b = n_ok;
    wait_ok(b);
    chk(n_ok == b + 1, "R9 ok after force-detect clears", n_ok - b, 1);

    // R9: overflow flag stuck
    of_stuck = 1; m_ib = OF; m_jump = FD;
    b = n_rt;
    wait_rt(b);
    chk(n_rt == b + 1, "R9 retry on overflow", n_rt - b, 1);
    of_stuck = 0;
    b = n_ok;
    wait_ok(b);
    chk(n_ok == b + 1, "R9 ok after overflow clears", n_ok - b, 1);

    bring_up(12, 2, "R10 final up");
    chk(viol == 0, "R11 request hold", viol, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule